// File: doc/BRIEF.md
# Dual-Pin Oversampled Audio Serial Receiver

This block takes eight-times-rate audio samples that arrive serially on two separate data pins, one carrying the left channel and one carrying the right. Both pins are shifted in parallel, most significant bit first. A bit clock times every bit, and a word strobe marks where each word sits. The block runs entirely on the bit clock. It delivers each completed pair of words in two 24-bit registers, together with a one-cycle valid pulse.

A 2-bit format control picks one of two framings. In left-aligned framing, a word starts at the strobe's falling edge and occupies the next 20 or 24 bit periods. In right-aligned framing, a word is the 20 or 24 bits that came just before the strobe's rising edge. A 2-bit length control picks 20-bit or 24-bit words. A 20-bit word is delivered in the upper bits of the output with the low bits zero.

Top module: `dpr_dual_rx`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) forces `left_word` and `right_word` to zero and `word_valid` to 0 at once, without waiting for a clock edge.
- R2: Left-aligned framing is selected by any `fmt_sel` value other than 2'b01. The strobe is sampled on each rising clock edge. Edge k is the first edge that samples the strobe low after sampling it high. Data bits are taken on edges k through k+N-1, MSB first, where N is the word length. After edge k+N-1 the words hold those bits and `word_valid` is 1.
- R3: Right-aligned framing is selected by `fmt_sel` = 2'b01. Edge r is the first edge that samples the strobe high after sampling it low. After edge r the words hold the N bits sampled on the N edges before r, MSB first, and `word_valid` is 1. The bit sampled on edge r itself is not part of that word.
- R4: `len_sel` = 2'b00 selects 20-bit words; any other value selects 24-bit words. A 20-bit word fills bits 23:4 of the output, and bits 3:0 are zero.
- R5: When the decoded framing changes, any word in progress is abandoned and no valid pulse comes from it.
- R6: `word_valid` lasts exactly one cycle. Both output words stay unchanged in every cycle in which `word_valid` is 0.
- R7: In left-aligned framing, bits that arrive after the N-th bit and before the next start edge are ignored. They cause no valid pulse and no change to either output word.
- R8: In right-aligned framing, a strobe rising edge produces no valid pulse unless at least N edges have passed since reset, since the framing change, or since the previous rising edge (that edge included).
- R9: In left-aligned framing, a new start edge during a word restarts the capture. The partial word is discarded.
- R10: The left and right pins are captured independently in the same cycles, and each lands only in its own output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and strobe are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe | input | 1 | Word strobe marking word boundaries |
| sdata_left | input | 1 | Serial data for the left channel |
| sdata_right | input | 1 | Serial data for the right channel |
| fmt_sel | input | 2 | Framing select: 2'b01 right-aligned, otherwise left-aligned |
| len_sel | input | 2 | Word length select: 2'b00 20 bits, otherwise 24 bits |
| left_word | output | 24 | Last completed left-channel word |
| right_word | output | 24 | Last completed right-channel word |
| word_valid | output | 1 | One-cycle pulse when both words have just been loaded |

## Verification
In right-aligned framing, the edge that latches a finished word is also an edge at which the shift register takes in a new bit. Both functions therefore land in the same cycle. The bench drives the strobe-high cycle with a data bit opposite to the word's last bit. It then judges that the latched word stops at the bit before the rising edge, and that a later rise does not pick up that extra bit too early. A second coincidence comes from switching framing between table vectors: the mode change and the counter state meet in one cycle. This is judged by the absence of stray valid pulses and by the correct next word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic {
        MODE_LEFT  = 1'b0,
        MODE_RIGHT = 1'b1
    } frame_mode_e;

    localparam logic [1:0] FMT_RIGHT_CODE = 2'b01;
    localparam logic [1:0] LEN_SHORT_CODE = 2'b00;

    function automatic frame_mode_e decode_mode(input logic [1:0] fmt);
        return (fmt == FMT_RIGHT_CODE) ? MODE_RIGHT : MODE_LEFT;
    endfunction
endpackage

// File: rtl/dpr_frame_ctrl.sv
module dpr_frame_ctrl
    import dpr_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  frame_mode_e mode,
    input  logic        len_short,
    output logic        cap,
    output logic        cap_next,
    output logic        valid
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);

    typedef struct packed {
        logic              strobe;
        frame_mode_e       mode;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CNT_W-1:0] target;
    logic fall, rise;

    assign target = len_short ? SHORT_CNT : FULL_CNT;
    assign fall   = st_q.strobe & ~strobe;
    assign rise   = ~st_q.strobe & strobe;

    always_comb begin
        st_d        = st_q;
        cap         = 1'b0;
        st_d.strobe = strobe;
        st_d.mode   = mode;
        if (mode != st_q.mode) begin
            st_d.cnt = '0;
        end else if (mode == MODE_LEFT) begin
            if (fall) begin
                st_d.cnt = ONE_CNT;
            end else if (st_q.cnt != '0) begin
                if (st_q.cnt >= target - ONE_CNT) begin
                    cap      = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + ONE_CNT;
                end
            end
        end else begin
            if (rise) begin
                cap      = (st_q.cnt >= target);
                st_d.cnt = ONE_CNT;
            end else if (st_q.cnt < FULL_CNT) begin
                st_d.cnt = st_q.cnt + ONE_CNT;
            end
        end
        st_d.valid = cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{strobe: 1'b0, mode: MODE_LEFT, cnt: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_next = (mode == MODE_LEFT);
    assign valid    = st_q.valid;
endmodule

// File: rtl/dpr_lane.sv
module dpr_lane #(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              cap,
    input  logic              cap_next,
    input  logic              len_short,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] word;
    } lane_t;

    lane_t st_d, st_q;
    logic [WORD_W-1:0] shift_next, src, short_form;

    assign shift_next = {st_q.shift[WORD_W-2:0], din};
    assign src        = cap_next ? shift_next : st_q.shift;

    generate
        if (WORD_W > SHORT_W) begin : g_pad
            assign short_form = {src[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
        end else begin : g_full
            assign short_form = src;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.shift = shift_next;
        if (cap) begin
            st_d.word = len_short ? short_form : src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
endmodule

// File: rtl/dpr_dual_rx.sv
module dpr_dual_rx
    import dpr_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20,
    parameter int LANES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              sdata_left,
    input  logic              sdata_right,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        len_sel,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_valid
);
    frame_mode_e       mode;
    logic              len_short, cap, cap_next;
    logic [LANES-1:0]  din_v;
    logic [WORD_W-1:0] word_v [LANES];

    assign mode      = decode_mode(fmt_sel);
    assign len_short = (len_sel == LEN_SHORT_CODE);
    assign din_v     = {sdata_right, sdata_left};

    dpr_frame_ctrl #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (frame_strobe),
        .mode     (mode),
        .len_short(len_short),
        .cap      (cap),
        .cap_next (cap_next),
        .valid    (word_valid)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dpr_lane #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) i_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (din_v[g]),
                .cap      (cap),
                .cap_next (cap_next),
                .len_short(len_short),
                .word     (word_v[g])
            );
        end
    endgenerate

    assign left_word  = word_v[0];
    assign right_word = word_v[1];
endmodule

// File: rtl/dpr_dual_rx_chk.sv
module dpr_dual_rx_chk #(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe,
    input logic [1:0]        fmt_sel,
    input logic [1:0]        len_sel,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word,
    input logic              word_valid
);
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(left_word) && $stable(right_word)));

    assert_short_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(len_sel) == 2'b00) |->
            ((left_word << SHORT_W) == '0 && (right_word << SHORT_W) == '0));

    assert_right_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(fmt_sel) == 2'b01) |->
            ($past(frame_strobe) && !$past(frame_strobe, 2)));
endmodule

bind dpr_dual_rx dpr_dual_rx_chk #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_strobe(frame_strobe),
    .fmt_sel     (fmt_sel),
    .len_sel     (len_sel),
    .left_word   (left_word),
    .right_word  (right_word),
    .word_valid  (word_valid)
);

// File: tb/test_dpr_dual_rx.sv
module test_dpr_dual_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        dl = 1'b0, dr = 1'b0;
    logic [1:0]  fmt = 2'b00, len = 2'b01;
    logic [23:0] lw, rw;
    logic        vld;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dpr_dual_rx i_dpr_dual_rx (
        .clk(clk), .rst_n(rst_n), .frame_strobe(strobe),
        .sdata_left(dl), .sdata_right(dr), .fmt_sel(fmt), .len_sel(len),
        .left_word(lw), .right_word(rw), .word_valid(vld)
    );

    // {fmt, len, left word, right word}
    localparam logic [51:0] VEC [6] = '{
        {2'b00, 2'b01, 24'hA5C3F1, 24'h5A3C0E},
        {2'b00, 2'b00, 24'h123456, 24'hFEDCBA},
        {2'b01, 2'b01, 24'h800001, 24'h7FFFFE},
        {2'b01, 2'b00, 24'hC0FFEE, 24'h0BADF0},
        {2'b11, 2'b11, 24'h369CF0, 24'hC9630F},
        {2'b01, 2'b10, 24'hFFFFFF, 24'h000000}
    };

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(input logic [23:0] w, input logic [1:0] l);
        return (l == 2'b00) ? {w[23:4], 4'h0} : w;
    endfunction

    task automatic send_left(input logic [23:0] wl, input logic [23:0] wr, input logic [1:0] l, input string req);
        int n = (l == 2'b00) ? 20 : 24;
        @(negedge clk); strobe = 1'b1; dl = 1'b0; dr = 1'b1;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); strobe = 1'b0; dl = wl[23-i]; dr = wr[23-i];
        end
        @(negedge clk);
        chk(vld === 1'b1, {req, " valid"}, {47'd0, vld}, 48'd1);
        chk(lw === expect_word(wl, l) && rw === expect_word(wr, l), {req, " words R10"},
            {lw, rw}, {expect_word(wl, l), expect_word(wr, l)});
        @(negedge clk);
        chk(vld === 1'b0, "R6 pulse one cycle", {47'd0, vld}, 48'd0);
    endtask

    task automatic send_right(input logic [23:0] wl, input logic [23:0] wr, input logic [1:0] l, input string req);
        int n = (l == 2'b00) ? 20 : 24;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); strobe = 1'b0; dl = 1'b1; dr = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk); dl = wl[23-i]; dr = wr[23-i];
        end
        @(negedge clk); strobe = 1'b1; dl = ~wl[24-n]; dr = ~wr[24-n];
        @(negedge clk);
        chk(vld === 1'b1, {req, " valid"}, {47'd0, vld}, 48'd1);
        chk(lw === expect_word(wl, l) && rw === expect_word(wr, l), {req, " words R10"},
            {lw, rw}, {expect_word(wl, l), expect_word(wr, l)});
        @(negedge clk);
        chk(vld === 1'b0, "R6 pulse one cycle", {47'd0, vld}, 48'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [47:0] held;
        bit seen;
        repeat (3) @(negedge clk);
        chk(lw === 24'd0 && rw === 24'd0 && vld === 1'b0, "R1 reset state", {lw, rw}, 48'd0);
        rst_n = 1'b1;

        // R8: right-aligned rise after too few edges
        @(negedge clk); fmt = 2'b01; strobe = 1'b0;
        repeat (4) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        chk(vld === 1'b0, "R8 short run no valid", {47'd0, vld}, 48'd0);
        @(negedge clk);
        chk(vld === 1'b0 && lw === 24'd0, "R8 words untouched", {lw, rw}, 48'd0);

        // table walk: R2 / R3 / R4 / R5 (framing changes between vectors)
        for (int v = 0; v < 6; v++) begin
            logic [51:0] e = VEC[v];
            @(negedge clk); fmt = e[51:50]; len = e[49:48];
            if (e[51:50] == 2'b01) send_right(e[47:24], e[23:0], e[49:48], "R3/R4 right");
            else                   send_left(e[47:24], e[23:0], e[49:48], "R2/R4/R5 left");
        end

        // R7: extra bits after a 20-bit left word are ignored
        @(negedge clk); fmt = 2'b00; len = 2'b00;
        send_left(24'h9E3779, 24'h61C886, 2'b00, "R2 left 20");
        held = {lw, rw};
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); dl = ~dl; dr = 1'b1;
            if (vld) seen = 1;
        end
        @(negedge clk);
        chk(!seen && !vld, "R7 no valid from extra bits", {47'd0, seen}, 48'd0);
        chk({lw, rw} === held, "R7 words unchanged", {lw, rw}, held);

        // R9: restart on a new start edge mid-word
        len = 2'b01;
        @(negedge clk); strobe = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); strobe = 1'b0; dl = 1'b1; dr = 1'b1;
        end
        send_left(24'h0F0F0F, 24'hF0F0F0, 2'b01, "R9 restart");

        // R5: framing change mid-word abandons it
        @(negedge clk); strobe = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); strobe = 1'b0; dl = 1'b1;
        end
        held = {lw, rw};
        fmt = 2'b01; seen = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (vld) seen = 1;
        end
        chk(!seen && {lw, rw} === held, "R5 abandoned word", {lw, rw}, held);

        // R1: asynchronous reset mid-run
        @(negedge clk); #2 rst_n = 1'b0; #1;
        chk(lw === 24'd0 && rw === 24'd0 && vld === 1'b0, "R1 async reset", {lw, rw}, 48'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule